// File: doc/BRIEF.md
# Cascaded Pacer Clock Generator

This block produces the periodic conversion trigger that starts each sample of an ADC scan controller. Two rate-dividing down-counters are chained. The first counts ticks of a selectable base rate. The second counts the terminal events of the first. The time between trigger pulses is therefore the base period multiplied by both divisors. Each base rate is a synchronous enable strobe made from the system clock by its own prescaler, so the whole block runs in a single clock domain.

Software, or a sequencer, first writes the outer divisor and then the inner divisor. The inner divisor write completes programming. After that, raising the gate starts the train of pulses. Dropping the gate freezes everything. Raising it again restarts both counters and the prescaler from their full values. A divisor written while the train is running is taken up when that counter next reloads, so the current interval is never cut short.

Top module: `pacer_cascade`

## Requirements
- R1: After reset `trig_o` is low and the block is disarmed. No trigger appears, even with `run_i` high, until `div1_wr_i` has been strobed.
- R2: The order of loading is the outer divisor (`div2_wr_i`) first and then the inner divisor (`div1_wr_i`). A `div2_wr_i` strobe on its own does not arm the block. The `div1_wr_i` strobe arms it, and if `run_i` is already high, counting starts on the next rising edge.
- R3: If `run_i` is high before rising edge E and the block is armed, edge E loads both counters. `trig_o` is first high after edge E + B·N1·N2. It then goes high every B·N1·N2 cycles. N1 and N2 are the inner and outer divisors. B is `FAST_DIV` when `base_sel_i` = 0.
- R4: With `base_sel_i` = 1, the same timing holds with B = `SLOW_DIV`.
- R5: Each trigger is exactly one clock cycle wide whenever B·N1·N2 > 1.
- R6: A divisor value of 0 counts as 65536.
- R7: While `run_i` is low, no new trigger is produced and the counters hold their values. On the next rise of `run_i`, both counters and the prescaler restart from their full values, not from where they stopped.
- R8: A divisor written while running takes effect at that counter's next reload. The interval in progress is not affected.
- R9: N1 = N2 = 1 with B = 1 gives a trigger in every cycle, so `trig_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div1_wr_i | input | 1 | Load strobe for the inner divisor (arms the block) |
| div2_wr_i | input | 1 | Load strobe for the outer divisor |
| div_data_i | input | DIV_W | Divisor value for either strobe |
| base_sel_i | input | 1 | Base rate: 0 divides by FAST_DIV, 1 divides by SLOW_DIV |
| run_i | input | 1 | Gate: high lets the counters run |
| trig_o | output | 1 | One-cycle conversion trigger |

## Verification
The assertions assume that the gate and both write strobes are synchronous to the clock. They also assume that `base_sel_i` changes only while the gate is low, because the prescaler that is not selected keeps counting and a change mid-run would shorten an interval. The stimulus changes every input at the falling edge. It switches the base rate and reprograms both divisors only with `run_i` low, except for the single case that deliberately rewrites the outer divisor during a run. It waits for the pipeline to drain after dropping the gate before it looks for silence.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    // base-rate selector encoding (index into the prescaler bank)
    typedef enum logic {
        BASE_FAST = 1'b0,
        BASE_SLOW = 1'b1
    } base_sel_e;

    localparam int unsigned NUM_BASES  = 2;
    localparam int unsigned NUM_STAGES = 2;
endpackage

// File: rtl/pacer_prescale.sv
module pacer_prescale #(
    parameter int unsigned DIV = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = tick_o ? '0 : cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pacer_rate_counter.sv
module pacer_rate_counter #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tc_o,
    output logic [DIV_W:0]   cnt_o
);
    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] full_val;

    // zero selects the largest count, 2**DIV_W
    assign full_val = (div_i == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, div_i};
    assign tc_o     = tick_i && (cnt_q == CW'(1));
    assign cnt_o    = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = full_val;
        end else if (tick_i) begin
            cnt_d = tc_o ? full_val : cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pacer_cascade.sv
module pacer_cascade
    import pacer_pkg::*;
#(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned FAST_DIV = 1,
    parameter int unsigned SLOW_DIV = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             div1_wr_i,
    input  logic             div2_wr_i,
    input  logic [DIV_W-1:0] div_data_i,
    input  logic             base_sel_i,
    input  logic             run_i,
    output logic             trig_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div1;
        logic [DIV_W-1:0] div2;
        logic             armed;
        logic             active;
        logic             trig;
    } state_t;

    state_t st_d, st_q;

    logic                  armed;
    logic                  active;
    logic                  start;
    logic [NUM_BASES-1:0]  base_tick;
    logic [NUM_STAGES-1:0] stage_tick;
    logic [NUM_STAGES-1:0] stage_tc;
    logic [DIV_W-1:0]      stage_div [NUM_STAGES];
    logic [DIV_W:0]        stage_cnt [NUM_STAGES];

    assign armed  = st_q.armed;
    assign active = st_q.active;
    assign start  = st_q.armed && run_i && !st_q.active;
    assign trig_o = st_q.trig;

    assign stage_div[0] = st_q.div1;
    assign stage_div[1] = st_q.div2;

    always_comb begin
        st_d = st_q;
        if (div2_wr_i) st_d.div2 = div_data_i;
        if (div1_wr_i) begin
            st_d.div1  = div_data_i;
            st_d.armed = 1'b1;
        end
        st_d.active = st_q.armed && run_i;
        st_d.trig   = stage_tc[NUM_STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar b = 0; b < NUM_BASES; b++) begin : g_base
        localparam int unsigned BDIV = (b == int'(BASE_FAST)) ? FAST_DIV : SLOW_DIV;
        pacer_prescale #(.DIV(BDIV)) u_pre (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (start),
            .run_i   (st_q.active),
            .tick_o  (base_tick[b])
        );
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_src_base
            assign stage_tick[s] = base_tick[base_sel_i];
        end else begin : g_src_prev
            assign stage_tick[s] = stage_tc[s-1];
        end
        pacer_rate_counter #(.DIV_W(DIV_W)) u_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .load_i (start),
            .tick_i (stage_tick[s]),
            .div_i  (stage_div[s]),
            .tc_o   (stage_tc[s]),
            .cnt_o  (stage_cnt[s])
        );
    end
endmodule

// File: rtl/pacer_cascade_chk.sv
module pacer_cascade_chk #(
    parameter int unsigned CW = 17
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          run_i,
    input logic          div1_wr_i,
    input logic          trig_o,
    input logic          armed_i,
    input logic          active_i,
    input logic          start_i,
    input logic          tc1_i,
    input logic          tc2_i,
    input logic [CW-1:0] cnt1_i,
    input logic [CW-1:0] cnt2_i
);
    a_r1_trig_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> $past(armed_i, 2)) else $error("R1 trigger while disarmed");

    a_r2_arm_by_inner_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(armed_i) |-> $past(div1_wr_i)) else $error("R2 armed without inner write");

    a_r3_outer_follows_inner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc2_i |-> tc1_i) else $error("R3 outer terminal count without inner");

    a_r6_counts_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_i |-> (cnt1_i != '0 && cnt2_i != '0)) else $error("R6 running with empty count");

    a_r7_trig_needs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> $past(run_i, 2)) else $error("R7 trigger without gate");

    a_r7_frozen_inner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_i && !start_i) |=> $stable(cnt1_i)) else $error("R7 inner count moved");

    a_r7_frozen_outer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_i && !start_i) |=> $stable(cnt2_i)) else $error("R7 outer count moved");
endmodule

bind pacer_cascade pacer_cascade_chk #(.CW(DIV_W + 1)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .div1_wr_i (div1_wr_i),
    .trig_o    (trig_o),
    .armed_i   (armed),
    .active_i  (active),
    .start_i   (start),
    .tc1_i     (stage_tc[0]),
    .tc2_i     (stage_tc[1]),
    .cnt1_i    (stage_cnt[0]),
    .cnt2_i    (stage_cnt[1])
);

// File: tb/test_pacer_cascade.sv
`timescale 1ns/100ps
module test_pacer_cascade;
    localparam int DIV_W = 16;
    localparam int FD    = 1;
    localparam int SD    = 10;
    localparam int LIMIT = 70000;

    // vector table: base select, inner div, outer div, first delay, interval
    localparam int NV = 6;
    localparam int V_SEL [NV] = '{0, 0, 1, 0, 1, 0};
    localparam int V_D1  [NV] = '{3, 1, 2, 5, 1, 7};
    localparam int V_D2  [NV] = '{4, 1, 3, 1, 1, 2};
    localparam int V_FST [NV] = '{13, 2, 61, 6, 11, 15};
    localparam int V_PER [NV] = '{12, 1, 60, 5, 10, 14};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             div1_wr, div2_wr;
    logic [DIV_W-1:0] div_data;
    logic             base_sel;
    logic             run;
    logic             trig;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pacer_cascade #(.DIV_W(DIV_W), .FAST_DIV(FD), .SLOW_DIV(SD)) i_pacer_cascade (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .div1_wr_i  (div1_wr),
        .div2_wr_i  (div2_wr),
        .div_data_i (div_data),
        .base_sel_i (base_sel),
        .run_i      (run),
        .trig_o     (trig)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called just after a falling edge; strobe spans one rising edge
    task automatic wr_div(input int which, input int val);
        div_data = DIV_W'(val);
        div1_wr  = (which == 1);
        div2_wr  = (which == 2);
        @(negedge clk);
        div1_wr  = 1'b0;
        div2_wr  = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (!trig && n < LIMIT);
    endtask

    task automatic count_trigs(input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (trig) hits++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, hits;
        rst_n = 1'b0; run = 1'b0; div1_wr = 1'b0; div2_wr = 1'b0;
        div_data = '0; base_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset trig", int'(trig), 0);
        rst_n = 1'b1;

        // R1: gate high but never programmed
        run = 1'b1;
        count_trigs(40, hits);
        chk("R1 silent before programming", hits, 0);
        // R2: outer write alone does not arm
        wr_div(2, 3);
        count_trigs(40, hits);
        chk("R2 outer write alone", hits, 0);
        // R2: inner write arms and starts on the next edge (P = 6)
        wr_div(1, 2);
        measure(n);
        chk("R2 start after inner write", n, 7);

        // table of vectors (R3 fast, R4 slow, R5 width, R9 continuous)
        for (int v = 0; v < NV; v++) begin
            run = 1'b0;
            repeat (3) @(negedge clk);
            count_trigs(30, hits);
            chk("R7 quiet while gated", hits, 0);
            base_sel = V_SEL[v][0];
            wr_div(2, V_D2[v]);
            wr_div(1, V_D1[v]);
            run = 1'b1;
            measure(n);
            chk(V_SEL[v] != 0 ? "R4 first slow" : "R3 first fast", n, V_FST[v]);
            measure(n);
            chk(V_PER[v] == 1 ? "R9 continuous" : "R3 R4 interval", n, V_PER[v]);
            @(posedge clk);
            @(negedge clk);
            chk("R5 pulse width", int'(trig), (V_PER[v] == 1) ? 1 : 0);
        end

        // R7: restart from full values after a pause mid-count
        run = 1'b0;
        repeat (3) @(negedge clk);
        base_sel = 1'b0;
        wr_div(2, 4);
        wr_div(1, 3);
        run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        repeat (10) @(negedge clk);
        run = 1'b1;
        measure(n);
        chk("R7 restart full", n, 13);

        // R8: outer divisor rewritten right after a trigger
        run = 1'b0;
        repeat (3) @(negedge clk);
        wr_div(2, 3);
        wr_div(1, 2);
        run = 1'b1;
        measure(n);
        chk("R8 first", n, 7);
        wr_div(2, 1);
        measure(n);
        chk("R8 current interval kept", n, 5);
        measure(n);
        chk("R8 new interval", n, 2);

        // R1: reset while running disarms
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset mid-run", int'(trig), 0);
        rst_n = 1'b1;
        count_trigs(40, hits);
        chk("R1 disarmed after reset", hits, 0);

        // R6: zero inner divisor counts 65536
        run = 1'b0;
        wr_div(2, 1);
        wr_div(1, 0);
        run = 1'b1;
        measure(n);
        chk("R6 zero divisor", n, 65537);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule